// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block is a bank of event counters that sits beside an address-translation unit. Each counter watches one event group chosen by a group index. Within that group it takes any subset of events, picked by a select mask with one bit per event. The counter advances once for every clock cycle in which at least one selected event is active. Up to five attribute filters (requester ID, domain ID, process address-space ID, ATS field, page-table field) can narrow counting to matching transactions. Event inputs may be single-cycle pulses or levels for occupancy-type events.

Software programs the bank through a small valid/ready register bus with 64-bit data. Reads return one cycle after the request. Commands written to a command register enable or disable a single counter, or freeze and unfreeze the whole bank. When a counter wraps it sets its bit in a sticky overflow register. Any overflow bit whose counter has its interrupt enable set raises a summary status bit, which drives the interrupt output. Read-only capability registers describe the bank, each event group and each counter.

Top module: `xlat_evt_counters`

## Requirements
- R1: After reset every counter reads 0, every counter is disabled, the bank is not frozen, and the overflow register, the summary status and `irq` are all 0.
- R2: `req_ready` is always 1. A read accepted on one clock edge drives `rsp_valid` high with its data for exactly the following cycle. Writes produce no response.
- R3: The bank capability register at 0x000 reads counters in [7:0], counter width in [15:8], group count in [23:16] and the supported-filter mask in [28:24]. Group g's supported select mask reads at 0x008+8*g.
- R4: Counter i has its block at 0x100+0x40*i. Its configuration register at +0x00 holds the select mask in [27:0], the group index in [31:28] and the interrupt enable in [32]. An enabled, unfrozen counter adds exactly one for each cycle in which any selected, supported event bit of its group (event input bit 28*group+bit) is high, however many are high at once.
- R5: Filter registers sit at +0x18 (requester ID, 16 bits), +0x20 (domain, 16 bits), +0x28 (PASID, 22 bits), +0x30 (ATS, 5 bits) and +0x38 (page table, 5 bits). Each holds the match value in its low bits and the enable in bit 31, and bits beyond the field read 0. An enabled filter passes only cycles whose attribute equals the value. A register cleared to 0 does not restrict counting.
- R6: Writing op 1 or op 2 with the counter index in [15:8] to the command register at 0x050 enables or disables that counter, and its value is kept. The command register reads the enable bits in [3:0].
- R7: Command op 3 freezes all counters and op 4 resumes them. Frozen counters keep their values, and bit 16 of the command register reads the frozen state.
- R8: The counter value at +0x08 is writable and reads zero-extended to 64 bits. It wraps modulo 2^48, and the wrap sets the counter's bit in the overflow register at 0x040.
- R9: Overflow bits are sticky and are cleared by writing 1s to 0x040. A wrap on the same edge as a clear of its bit leaves the bit set.
- R10: The summary status at 0x048 bit 0 sets on the edge after any overflow bit whose counter has interrupt enable 1 is set. It stays set until 1 is written to bit 0, and `irq` equals it. Overflows with interrupt enable 0 do not raise it.
- R11: A group index of 5 or more, or select bits outside the group's supported mask, never advance the counter.
- R12: The per-counter capability register at +0x10 reads the counter width in [7:0], overflow-interrupt support in [8] and the supported-group mask in [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address, 8-byte aligned |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| evt | input | 140 | Event inputs, 28 per group, 5 groups |
| att_rid | input | 16 | Requester ID of the current transaction |
| att_dom | input | 16 | Domain ID of the current transaction |
| att_pasid | input | 22 | PASID of the current transaction |
| att_ats | input | 5 | ATS attribute of the current transaction |
| att_pt | input | 5 | Page-table attribute of the current transaction |
| irq | output | 1 | Summary overflow interrupt |

## Verification
The bench builds the bank with its defaults: four 48-bit counters, five groups of 28 events, all filters supported, and the group masks 0xF, 0x61, 0x3FF, 0xF and 0x7. Preloading a counter to just below 2^48 puts the wrap, the overflow bit, the summary interrupt and the set-versus-clear collision a few cycles away. The group 1 mask 0x61 leaves bit 1 unsupported, so it serves as the case of a select bit that must be ignored.

// File: rtl/xlat_evt_counters.sv
module xlat_evt_counters #(
  parameter int NCNT = 4,
  parameter int CW   = 48,
  parameter int NGRP = 5,
  parameter int SELW = 28,
  parameter int AW   = 12,
  parameter int DW   = 64,
  parameter logic [NGRP*SELW-1:0] GRP_CAP = {28'h0000007, 28'h000000F, 28'h00003FF, 28'h0000061, 28'h000000F},
  parameter logic [4:0] FLT_SUP = 5'h1F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  input  logic [NGRP*SELW-1:0] evt,
  input  logic [15:0]          att_rid,
  input  logic [15:0]          att_dom,
  input  logic [21:0]          att_pasid,
  input  logic [4:0]           att_ats,
  input  logic [4:0]           att_pt,
  output logic                 irq
);
  localparam int NFLT   = 5;
  localparam int FVW    = 22;
  localparam int GW     = 4;
  localparam int CIDX_W = 2;
  localparam logic [AW-1:0] A_CAP  = AW'(12'h000);
  localparam logic [AW-1:0] A_GCAP = AW'(12'h008);
  localparam logic [AW-1:0] A_OVF  = AW'(12'h040);
  localparam logic [AW-1:0] A_INT  = AW'(12'h048);
  localparam logic [AW-1:0] A_CMD  = AW'(12'h050);
  localparam logic [7:0] OP_EN = 8'd1, OP_DIS = 8'd2, OP_FRZ = 8'd3, OP_UNFRZ = 8'd4;

  function automatic logic [FVW-1:0] fmask(input int f);
    case (f)
      0, 1:    fmask = 22'h00FFFF;
      2:       fmask = 22'h3FFFFF;
      default: fmask = 22'h00001F;
    endcase
  endfunction

  logic wr, rd, in_cnt, cmd_wr, ovf_clr, int_clr;
  logic [CIDX_W-1:0] cidx;
  logic [2:0] creg;
  logic [7:0] op, cmd_idx;

  assign req_ready = 1'b1;
  assign wr      = req_valid & req_write;
  assign rd      = req_valid & ~req_write;
  assign in_cnt  = req_addr[AW-1:8] == (AW-8)'(1);
  assign cidx    = req_addr[7:6];
  assign creg    = req_addr[5:3];
  assign cmd_wr  = wr && req_addr == A_CMD;
  assign ovf_clr = wr && req_addr == A_OVF;
  assign int_clr = wr && req_addr == A_INT && req_wdata[0];
  assign op      = req_wdata[7:0];
  assign cmd_idx = req_wdata[15:8];

  logic unused_bits;
  assign unused_bits = ^{req_addr[2:0], req_wdata[DW-1:CW]};

  logic [SELW-1:0] sel_q [NCNT];
  logic [GW-1:0]   grp_q [NCNT];
  logic [CW-1:0]   cnt_q [NCNT];
  logic [FVW-1:0]  fval_q [NCNT][NFLT];
  logic [NFLT-1:0] fen_q [NCNT];
  logic [NCNT-1:0] ie_q, en_q, ovf_q, hit, wrap, cnt_wr, grp_ok, fok;
  logic [SELW-1:0] evg [NCNT];
  logic            frz_q, int_q;
  logic [FVW-1:0]  attr [NFLT];
  logic [DW-1:0]   rdata_n;

  assign attr[0] = {6'b0, att_rid};
  assign attr[1] = {6'b0, att_dom};
  assign attr[2] = att_pasid;
  assign attr[3] = {17'b0, att_ats};
  assign attr[4] = {17'b0, att_pt};

  always_comb begin
    for (int i = 0; i < NCNT; i++) begin
      evg[i]    = '0;
      grp_ok[i] = 1'b0;
      for (int g = 0; g < NGRP; g++) begin
        if (grp_q[i] == GW'(g)) begin
          evg[i]    = evt[g*SELW +: SELW] & GRP_CAP[g*SELW +: SELW];
          grp_ok[i] = 1'b1;
        end
      end
      fok[i] = 1'b1;
      for (int f = 0; f < NFLT; f++)
        if (fen_q[i][f] && fval_q[i][f] != attr[f]) fok[i] = 1'b0;
      hit[i]    = en_q[i] & ~frz_q & grp_ok[i] & (|(evg[i] & sel_q[i])) & fok[i];
      cnt_wr[i] = wr & in_cnt & (cidx == CIDX_W'(i)) & (creg == 3'd1);
      wrap[i]   = hit[i] & (&cnt_q[i]) & ~cnt_wr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      en_q  <= '0;
      ie_q  <= '0;
      ovf_q <= '0;
      int_q <= 1'b0;
      for (int i = 0; i < NCNT; i++) begin
        sel_q[i] <= '0;
        grp_q[i] <= '0;
        cnt_q[i] <= '0;
        fen_q[i] <= '0;
        for (int f = 0; f < NFLT; f++) fval_q[i][f] <= '0;
      end
    end else begin
      if (cmd_wr && op == OP_FRZ)   frz_q <= 1'b1;
      if (cmd_wr && op == OP_UNFRZ) frz_q <= 1'b0;
      for (int i = 0; i < NCNT; i++) begin
        if (cmd_wr && cmd_idx == 8'(i) && op == OP_EN)  en_q[i] <= 1'b1;
        if (cmd_wr && cmd_idx == 8'(i) && op == OP_DIS) en_q[i] <= 1'b0;
        if (wr && in_cnt && cidx == CIDX_W'(i) && creg == 3'd0) begin
          sel_q[i] <= req_wdata[SELW-1:0];
          grp_q[i] <= req_wdata[31:28];
          ie_q[i]  <= req_wdata[32];
        end
        for (int f = 0; f < NFLT; f++) begin
          if (wr && in_cnt && cidx == CIDX_W'(i) && creg == 3'(f + 3)) begin
            fval_q[i][f] <= req_wdata[FVW-1:0] & fmask(f);
            fen_q[i][f]  <= req_wdata[31] & FLT_SUP[f];
          end
        end
        if (cnt_wr[i])   cnt_q[i] <= req_wdata[CW-1:0];
        else if (hit[i]) cnt_q[i] <= cnt_q[i] + CW'(1);
      end
      ovf_q <= (ovf_q & ~(ovf_clr ? req_wdata[NCNT-1:0] : '0)) | wrap;
      int_q <= (int_q & ~int_clr) | (|(ovf_q & ie_q));
    end
  end

  assign irq = int_q;

  always_comb begin
    rdata_n = '0;
    if (req_addr == A_CAP)
      rdata_n = {32'b0, 3'b0, FLT_SUP, 8'(NGRP), 8'(CW), 8'(NCNT)};
    for (int g = 0; g < NGRP; g++)
      if (req_addr == A_GCAP + AW'(8 * g)) rdata_n = DW'(GRP_CAP[g*SELW +: SELW]);
    if (req_addr == A_OVF) rdata_n = DW'(ovf_q);
    if (req_addr == A_INT) rdata_n = DW'(int_q);
    if (req_addr == A_CMD) begin
      rdata_n[NCNT-1:0] = en_q;
      rdata_n[16]       = frz_q;
    end
    if (in_cnt) begin
      for (int i = 0; i < NCNT; i++) begin
        if (cidx == CIDX_W'(i)) begin
          case (creg)
            3'd0: rdata_n = {31'b0, ie_q[i], grp_q[i], sel_q[i]};
            3'd1: rdata_n = DW'(cnt_q[i]);
            3'd2: begin
              rdata_n[7:0]        = 8'(CW);
              rdata_n[8]          = 1'b1;
              rdata_n[16 +: NGRP] = '1;
            end
            default: begin
              rdata_n[FVW-1:0] = fval_q[i][creg - 3'd3];
              rdata_n[31]      = fen_q[i][creg - 3'd3];
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata_n;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rd |=> rsp_valid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n) !rd |=> !rsp_valid); // R2
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n) (|(ovf_q & ie_q)) |=> irq); // R10

  for (genvar i = 0; i < NCNT; i++) begin : g_chk
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr[i] |=> (cnt_q[i] - $past(cnt_q[i])) <= CW'(1)); // R4
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[i] && !cnt_wr[i]) |=> cnt_q[i] == $past(cnt_q[i])); // R6
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q && !cnt_wr[i]) |=> cnt_q[i] == $past(cnt_q[i])); // R7
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[i] |=> (ovf_q[i] && cnt_q[i] == '0)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[i] && !(ovf_clr && req_wdata[i])) |=> ovf_q[i]); // R9
  end
endmodule

// File: tb/xlat_evt_counters_bench.sv
module xlat_evt_counters_bench;
  localparam int EVW = 140;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [63:0] rsp_rdata;
  logic [EVW-1:0] evt = '0;
  logic [15:0] att_rid = '0, att_dom = '0;
  logic [21:0] att_pasid = '0;
  logic [4:0] att_ats = '0, att_pt = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_evt_counters u_xlat_evt_counters (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt(evt),
    .att_rid(att_rid), .att_dom(att_dom), .att_pasid(att_pasid),
    .att_ats(att_ats), .att_pt(att_pt), .irq(irq));

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic rdchk(input string r, input logic [11:0] a, input logic [63:0] exp);
    logic [63:0] d;
    rd(a, d);
    chk(r, d, exp);
  endtask

  task automatic drive(input int b, input int n);
    @(negedge clk);
    evt[b] = 1'b1;
    repeat (n) @(negedge clk);
    evt[b] = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 irq", {63'b0, irq}, 64'h0);
    chk("R2 ready", {63'b0, req_ready}, 64'h1);
    rdchk("R1 ovf", 12'h040, 64'h0);
    rdchk("R1 int", 12'h048, 64'h0);
    rdchk("R1 cmd", 12'h050, 64'h0);
    rdchk("R1 cnt0", 12'h108, 64'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h000;
    @(negedge clk);
    chk("R2 rsp_valid", {63'b0, rsp_valid}, 64'h1);
    d = rsp_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2 rsp_drop", {63'b0, rsp_valid}, 64'h0);
    chk("R3 cap", d, 64'h1F053004);
  endtask

  task automatic t_caps();
    rdchk("R3 gcap0", 12'h008, 64'hF);
    rdchk("R3 gcap1", 12'h010, 64'h61);
    rdchk("R3 gcap2", 12'h018, 64'h3FF);
    rdchk("R3 gcap4", 12'h028, 64'h7);
    rdchk("R12 ccap0", 12'h110, 64'h001F0130);
    rdchk("R12 ccap3", 12'h1D0, 64'h001F0130);
  endtask

  task automatic t_count();
    wr(12'h100, 64'h1);
    wr(12'h050, 64'h0001);
    rdchk("R4 cfg readback", 12'h100, 64'h1);
    drive(0, 5);
    rdchk("R4 single event", 12'h108, 64'd5);
    wr(12'h100, 64'h3);
    @(negedge clk); evt[1:0] = 2'b11;
    repeat (3) @(negedge clk); evt[1:0] = 2'b00;
    rdchk("R4 two events one step", 12'h108, 64'd8);
  endtask

  task automatic t_ignore();
    wr(12'h100, 64'h7FFFFFFF);
    @(negedge clk); evt = '1;
    repeat (4) @(negedge clk); evt = '0;
    rdchk("R11 group out of range", 12'h108, 64'd8);
    wr(12'h100, 64'h10000002);
    drive(29, 4);
    rdchk("R11 unsupported select", 12'h108, 64'd8);
    wr(12'h100, 64'h1);
  endtask

  task automatic t_enable();
    wr(12'h050, 64'h0002);
    drive(0, 4);
    rdchk("R6 disabled holds", 12'h108, 64'd8);
    rdchk("R6 enable bit clear", 12'h050, 64'h0);
    wr(12'h050, 64'h0001);
    drive(0, 2);
    rdchk("R6 resumed", 12'h108, 64'd10);
  endtask

  task automatic t_freeze();
    wr(12'h050, 64'h0003);
    drive(0, 3);
    rdchk("R7 frozen holds", 12'h108, 64'd10);
    rdchk("R7 frozen state", 12'h050, 64'h10001);
    wr(12'h050, 64'h0004);
    drive(0, 1);
    rdchk("R7 unfrozen", 12'h108, 64'd11);
  endtask

  task automatic t_filter();
    wr(12'h180, 64'h30000001);
    wr(12'h050, 64'h0201);
    wr(12'h198, 64'h80001234);
    att_rid = 16'h1234; drive(84, 3);
    att_rid = 16'h1235; drive(84, 2);
    rdchk("R5 requester filter", 12'h188, 64'd3);
    wr(12'h1A8, 64'h802ABCDE);
    att_rid = 16'h1234; att_pasid = 22'h2ABCDE; drive(84, 2);
    att_pasid = 22'h2ABCDF; drive(84, 2);
    rdchk("R5 pasid filter", 12'h188, 64'd5);
    wr(12'h198, 64'h0);
    wr(12'h1A8, 64'h0);
    rdchk("R5 cleared reg", 12'h198, 64'h0);
    att_rid = 16'h5555; att_pasid = 22'h0; drive(84, 4);
    rdchk("R5 zero filter open", 12'h188, 64'd9);
    wr(12'h1B0, 64'hFFFFFFFF);
    rdchk("R5 ats field width", 12'h1B0, 64'h8000001F);
    att_ats = 5'h1F; drive(84, 2);
    att_ats = 5'h1E; drive(84, 1);
    rdchk("R5 ats filter", 12'h188, 64'd11);
    wr(12'h1B0, 64'h0);
  endtask

  task automatic t_wrap();
    wr(12'h140, 64'h1_0000_0002);
    wr(12'h148, 64'hFFFF_FFFF_FFFF_FFFE);
    rdchk("R8 zero extended", 12'h148, 64'h0000_FFFF_FFFF_FFFE);
    wr(12'h050, 64'h0101);
    drive(1, 3);
    rdchk("R8 wrapped value", 12'h148, 64'd1);
    rdchk("R8 overflow bit", 12'h040, 64'h2);
    rdchk("R10 status set", 12'h048, 64'h1);
    chk("R10 irq high", {63'b0, irq}, 64'h1);
    wr(12'h040, 64'h2);
    rdchk("R9 cleared", 12'h040, 64'h0);
    rdchk("R10 status sticky", 12'h048, 64'h1);
    wr(12'h048, 64'h1);
    rdchk("R10 status cleared", 12'h048, 64'h0);
    chk("R10 irq low", {63'b0, irq}, 64'h0);
  endtask

  task automatic t_no_ie();
    wr(12'h1C0, 64'h40000001);
    wr(12'h1C8, 64'hFFFF_FFFF_FFFF);
    wr(12'h050, 64'h0301);
    drive(112, 1);
    rdchk("R8 wrap to zero", 12'h1C8, 64'h0);
    rdchk("R8 overflow bit3", 12'h040, 64'h8);
    rdchk("R10 no ie no status", 12'h048, 64'h0);
    chk("R10 no ie irq", {63'b0, irq}, 64'h0);
    wr(12'h040, 64'h8);
  endtask

  task automatic t_race();
    wr(12'h148, 64'hFFFF_FFFF_FFFF);
    @(negedge clk);
    evt[1] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_wdata = 64'h2;
    @(negedge clk);
    evt[1] = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rdchk("R9 set beats clear", 12'h040, 64'h2);
    rdchk("R9 counter wrapped", 12'h148, 64'h0);
    wr(12'h040, 64'h2);
    rdchk("R9 cleared after", 12'h040, 64'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_caps();
    t_count();
    t_ignore();
    t_enable();
    t_freeze();
    t_filter();
    t_wrap();
    t_no_ie();
    t_race();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule